// File: doc/BRIEF.md
# Adaptive Intra-Field Luma/Chroma Separator

This block takes a continuous stream of 8-bit composite video samples, taken at four times the colour subcarrier on a burst-locked clock, and splits it into a luminance stream and a signed chroma stream. For each output pixel it looks at three samples: the pixel itself, the pixel directly above it and the pixel directly below it. When both vertical neighbours are close to the pixel, the vertical detail is coherent, so a three-line comb gives the luminance. Otherwise the block falls back to a horizontal bandpass split along the pixel's own line.

For the 525-line standard the neighbour lines are one line away. For the three 625-line style standards they are two lines away, so the subcarrier phase cancels in the comb. A 2-bit separation mode selects adaptive operation, forced bandpass operation, or a pass-through mode in which the composite sample emerges unchanged as luminance. Line memories are modelled as internal shift buffers of `LINE_LEN` samples each. Chroma is always the centre composite sample minus the luminance, so the two outputs add back to the delayed composite.

Top module: `yc_separator`

## Requirements
- R1: In the cycle after any clock edge with `rst_n` low, `out_valid`, `y_out` and `c_out` are all zero.
- R2: Every pixel takes the same number of clock edges from input to output in every mode. S is the line spacing: `LINE_LEN` when `tv_std` is 00, and 2*`LINE_LEN` otherwise. A sample x[k] presented at edge k is the centre pixel of the outputs seen just after edge k+S+19. `out_valid` there equals the `in_valid` presented with x[k].
- R3: With `sep_mode` = 11 (pass-through), `y_out` = x[k] and `c_out` = 0.
- R4: With `sep_mode` = 10 (bandpass only), `y_out` = floor((x[k-2] + 2*x[k] + x[k+2]) / 4).
- R5: With `sep_mode` = 00, and likewise for the unassigned code 01, the comb applies when |x[k+S] - x[k]| < `corr_thresh` and |x[k-S] - x[k]| < `corr_thresh`, both strict and unsigned. The comb gives `y_out` = floor((x[k+S] + 2*x[k] + x[k-S]) / 4). Any other pixel uses the R4 formula.
- R6: `c_out` is the 9-bit two's complement value x[k] - `y_out`, so `y_out` + `c_out` = x[k]. It never takes the value -256.
- R7: With `corr_thresh` = 0 the comb is never chosen, and adaptive mode gives the R4 result for every pixel.
- R8: `tv_std` picks the line spacing: 00 = 525-line standard, one line; 01, 10 and 11 = 625-line and the two variant standards, two lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the subcarrier |
| rst_n | input | 1 | Synchronous active-low reset |
| tv_std | input | 2 | Standard code: 00 525-line, 01/10/11 two-line spacing |
| sep_mode | input | 2 | 00/01 adaptive, 10 bandpass only, 11 pass-through |
| corr_thresh | input | 8 | Vertical difference limit below which the comb is used |
| in_valid | input | 1 | Marks the input sample as active picture |
| cvbs_in | input | 8 | Composite input sample |
| out_valid | output | 1 | `in_valid` of the centre sample, delayed with it |
| y_out | output | 8 | Luminance |
| c_out | output | 9 | Chroma, two's complement |

## Verification
Bad state in the line buffers shows up as wrong luminance exactly S+20 cycles after the corrupted sample entered. Such a fault also breaks `out_valid` alignment, so it cannot hide behind data that looks plausible. A fault in the horizontal taps or the correlation decision changes `y_out` and `c_out` 20 cycles after the centre sample reaches the tap bank. The bench sweeps every standard, every mode code and four data/threshold patterns, and compares every output cycle against arithmetic expectations. A wrong spacing, wrong tap, wrong rounding or off-by-one threshold is therefore caught on the first affected pixel.

// File: rtl/yc_pkg.sv
// Shared types and arithmetic helpers for the luma/chroma separator.
// Assumes unsigned PIX_W-bit composite samples.
package yc_pkg;

    parameter int unsigned PIX_W = 8;

    typedef enum logic [1:0] {
        SEP_ADAPT     = 2'b00,
        SEP_ADAPT_ALT = 2'b01,
        SEP_BPF       = 2'b10,
        SEP_THRU      = 2'b11
    } sep_mode_e;

    typedef enum logic [1:0] {
        STD_525   = 2'b00,
        STD_625   = 2'b01,
        STD_625_M = 2'b10,
        STD_625_N = 2'b11
    } tv_std_e;

    typedef struct packed {
        logic                    valid;
        logic [PIX_W-1:0]        y;
        logic signed [PIX_W:0]   c;
    } yc_pix_t;

    // Unsigned magnitude of the difference of two samples.
    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] p,
                                                   input logic [PIX_W-1:0] q);
        return (p > q) ? (p - q) : (q - p);
    endfunction

    // Floor of (e0 + 2*mid + e1) / 4, exact at full width.
    function automatic logic [PIX_W-1:0] tri_avg(input logic [PIX_W-1:0] e0,
                                                  input logic [PIX_W-1:0] mid,
                                                  input logic [PIX_W-1:0] e1);
        logic [PIX_W+1:0] s;
        s = {2'b00, e0} + {1'b0, mid, 1'b0} + {2'b00, e1};
        return s[PIX_W+1:2];
    endfunction

endpackage

// File: rtl/yc_line_delay.sv
// One line memory modelled as a shift buffer of LEN words.
// Assumes a sample every clock; the output is the input delayed LEN cycles.
module yc_line_delay #(
    parameter int unsigned W   = 8,
    parameter int unsigned LEN = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] sr [LEN];

    // Shift one word per clock, clearing the whole line on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(LEN); i++) sr[i] <= '0;
        end else begin
            sr[0] <= d_in;
            for (int i = 1; i < int'(LEN); i++) sr[i] <= sr[i-1];
        end
    end

    assign d_out = sr[LEN-1];

endmodule

// File: rtl/yc_tap_bank.sv
// Chain of four data line delays plus two valid-flag line delays.
// Presents the newest, centre and oldest line taps. The spacing is one
// line for the 525-line standard and two lines for the others.
module yc_tap_bank
    import yc_pkg::*;
#(
    parameter int unsigned LINE_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tv_std_e          std,
    input  logic             x_valid,
    input  logic [PIX_W-1:0] x_data,
    output logic [PIX_W-1:0] tap_new,
    output logic [PIX_W-1:0] tap_ctr,
    output logic             tap_ctr_v,
    output logic [PIX_W-1:0] tap_old
);

    localparam int unsigned N_DLINES = 4;
    localparam int unsigned N_VLINES = N_DLINES / 2;

    logic [PIX_W-1:0] dchain [N_DLINES+1];
    logic             vchain [N_VLINES+1];

    assign dchain[0] = x_data;
    assign vchain[0] = x_valid;

    generate
        for (genvar g = 0; g < N_DLINES; g++) begin : g_dline
            yc_line_delay #(.W(PIX_W), .LEN(LINE_LEN)) u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .d_in  (dchain[g]),
                .d_out (dchain[g+1])
            );
        end
        for (genvar g = 0; g < N_VLINES; g++) begin : g_vline
            yc_line_delay #(.W(1), .LEN(LINE_LEN)) u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .d_in  (vchain[g]),
                .d_out (vchain[g+1])
            );
        end
    endgenerate

    // Pick centre and oldest taps according to the standard's line spacing.
    always_comb begin
        tap_new = dchain[0];
        if (std == STD_525) begin
            tap_ctr   = dchain[1];
            tap_ctr_v = vchain[1];
            tap_old   = dchain[2];
        end else begin
            tap_ctr   = dchain[2];
            tap_ctr_v = vchain[2];
            tap_old   = dchain[4];
        end
    end

endmodule

// File: rtl/yc_sep_core.sv
// Horizontal alignment, correlation detector, comb and bandpass luma
// estimates, and mode selection. The centre pixel is the centre tap
// delayed two samples, so bandpass taps two samples either side exist.
// Four register stages from the centre tap to pix_q.
module yc_sep_core
    import yc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sep_mode_e        mode,
    input  logic [PIX_W-1:0] thresh,
    input  logic [PIX_W-1:0] tap_new,
    input  logic [PIX_W-1:0] tap_ctr,
    input  logic             tap_ctr_v,
    input  logic [PIX_W-1:0] tap_old,
    output yc_pix_t          pix_q
);

    localparam int unsigned H_TAPS = 4;
    localparam int unsigned V_ALN  = 2;

    logic [PIX_W-1:0] hb [H_TAPS];
    logic             hv [V_ALN];
    logic [PIX_W-1:0] ha [V_ALN];
    logic [PIX_W-1:0] hc [V_ALN];

    logic [PIX_W-1:0] mid;
    logic             corr_now;
    logic [PIX_W-1:0] ycomb_now;
    logic [PIX_W-1:0] ybpf_now;

    logic             s1_valid;
    logic [PIX_W-1:0] s1_ctr;
    logic [PIX_W-1:0] s1_ycomb;
    logic [PIX_W-1:0] s1_ybpf;
    logic             s1_corr;

    logic [PIX_W-1:0] y_sel;
    yc_pix_t          pix_d;

    // Horizontal delay of the centre line and two-sample alignment of neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(H_TAPS); i++) hb[i] <= '0;
            for (int i = 0; i < int'(V_ALN); i++) begin
                hv[i] <= 1'b0;
                ha[i] <= '0;
                hc[i] <= '0;
            end
        end else begin
            hb[0] <= tap_ctr;
            hv[0] <= tap_ctr_v;
            ha[0] <= tap_new;
            hc[0] <= tap_old;
            for (int i = 1; i < int'(H_TAPS); i++) hb[i] <= hb[i-1];
            for (int i = 1; i < int'(V_ALN); i++) begin
                hv[i] <= hv[i-1];
                ha[i] <= ha[i-1];
                hc[i] <= hc[i-1];
            end
        end
    end

    // Correlation test and both luma estimates around the centre pixel.
    always_comb begin
        mid       = hb[1];
        corr_now  = (abs_diff(ha[1], mid) < thresh) && (abs_diff(hc[1], mid) < thresh);
        ycomb_now = tri_avg(ha[1], mid, hc[1]);
        ybpf_now  = tri_avg(tap_ctr, mid, hb[3]);
    end

    // Register the estimates and the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ctr   <= '0;
            s1_ycomb <= '0;
            s1_ybpf  <= '0;
            s1_corr  <= 1'b0;
        end else begin
            s1_valid <= hv[1];
            s1_ctr   <= mid;
            s1_ycomb <= ycomb_now;
            s1_ybpf  <= ybpf_now;
            s1_corr  <= corr_now;
        end
    end

    // Choose luma by mode; chroma is the residual of the centre sample.
    always_comb begin
        unique case (mode)
            SEP_THRU: y_sel = s1_ctr;
            SEP_BPF:  y_sel = s1_ybpf;
            default:  y_sel = s1_corr ? s1_ycomb : s1_ybpf;
        endcase
        pix_d.valid = s1_valid;
        pix_d.y     = y_sel;
        pix_d.c     = $signed({1'b0, s1_ctr}) - $signed({1'b0, y_sel});
    end

    // Output register of the core.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

endmodule

// File: rtl/yc_pipe_pad.sv
// Fixed delay of DEPTH cycles on a separated pixel, padding the core
// to the block's fixed processing latency. DEPTH of zero passes through.
module yc_pipe_pad
    import yc_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  yc_pix_t d,
    output yc_pix_t q
);

    generate
        if (DEPTH == 0) begin : g_none
            assign q = d;
        end else begin : g_sr
            yc_pix_t sr [DEPTH];

            // Advance the pixel one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(DEPTH); i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < int'(DEPTH); i++) sr[i] <= sr[i-1];
                end
            end

            assign q = sr[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/yc_separator.sv
// Top of the adaptive luma/chroma separator. Assumes one sample per clock
// at four times the subcarrier. Total latency is the line spacing plus
// PIPE_LAT cycles, identical in every mode.
module yc_separator
    import yc_pkg::*;
#(
    parameter int unsigned LINE_LEN = 64,
    parameter int unsigned PIPE_LAT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tv_std,
    input  logic [1:0]       sep_mode,
    input  logic [PIX_W-1:0] corr_thresh,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] cvbs_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] y_out,
    output logic [PIX_W:0]   c_out
);

    localparam int unsigned CORE_LAT  = 4;
    localparam int unsigned PAD_DEPTH = PIPE_LAT - CORE_LAT;

    logic [PIX_W-1:0] tap_new;
    logic [PIX_W-1:0] tap_ctr;
    logic             tap_ctr_v;
    logic [PIX_W-1:0] tap_old;
    yc_pix_t          core_pix;
    yc_pix_t          out_pix;

    yc_tap_bank #(.LINE_LEN(LINE_LEN)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .std       (tv_std_e'(tv_std)),
        .x_valid   (in_valid),
        .x_data    (cvbs_in),
        .tap_new   (tap_new),
        .tap_ctr   (tap_ctr),
        .tap_ctr_v (tap_ctr_v),
        .tap_old   (tap_old)
    );

    yc_sep_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (sep_mode_e'(sep_mode)),
        .thresh    (corr_thresh),
        .tap_new   (tap_new),
        .tap_ctr   (tap_ctr),
        .tap_ctr_v (tap_ctr_v),
        .tap_old   (tap_old),
        .pix_q     (core_pix)
    );

    yc_pipe_pad #(.DEPTH(PAD_DEPTH)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (core_pix),
        .q     (out_pix)
    );

    assign out_valid = out_pix.valid;
    assign y_out     = out_pix.y;
    assign c_out     = out_pix.c;

endmodule

// File: rtl/yc_separator_chk.sv
// Property checker for yc_separator, attached by bind below.
module yc_separator_chk
    import yc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] corr_thresh,
    input logic             out_valid,
    input logic [PIX_W-1:0] y_out,
    input logic [PIX_W:0]   c_out,
    input yc_pix_t          core_pix,
    input logic [PIX_W-1:0] s1_ctr,
    input logic             s1_corr
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && y_out == '0 && c_out == '0)); // R1

    AST_SUM_RECONSTRUCTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($signed({1'b0, core_pix.y}) + core_pix.c)
                          == $signed({1'b0, $past(s1_ctr)}))); // R6

    AST_CHROMA_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        c_out != {1'b1, {PIX_W{1'b0}}}); // R6

    AST_ZERO_THRESH_NO_COMB: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(corr_thresh) == '0) |-> !s1_corr); // R7

endmodule

bind yc_separator yc_separator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .corr_thresh (corr_thresh),
    .out_valid   (out_valid),
    .y_out       (y_out),
    .c_out       (c_out),
    .core_pix    (u_core.pix_q),
    .s1_ctr      (u_core.s1_ctr),
    .s1_corr     (u_core.s1_corr)
);

// File: tb/yc_separator_tb.sv
// Sweeps all standards, all mode codes and four data/threshold patterns
// on a short line, checking every output cycle against arithmetic models.
module yc_separator_tb;

    localparam int LL    = 8;
    localparam int LAT   = 20;
    localparam int NSAMP = 70;
    localparam int HMAX  = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tv_std = 2'b00;
    logic [1:0] sep_mode = 2'b00;
    logic [7:0] corr_thresh = 8'd0;
    logic       in_valid = 1'b0;
    logic [7:0] cvbs_in = 8'd0;
    logic       out_valid;
    logic [7:0] y_out;
    logic [8:0] c_out;

    int n_chk = 0;
    int n_err = 0;
    int hd [HMAX];
    int hv [HMAX];
    int span;
    int e;
    int cur_std, cur_mode, cur_pat;
    bit done = 1'b0;

    always #10 clk = ~clk;

    yc_separator #(.LINE_LEN(LL), .PIPE_LAT(LAT)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tv_std      (tv_std),
        .sep_mode    (sep_mode),
        .corr_thresh (corr_thresh),
        .in_valid    (in_valid),
        .cvbs_in     (cvbs_in),
        .out_valid   (out_valid),
        .y_out       (y_out),
        .c_out       (c_out)
    );

    function automatic int hx(int i);
        return (i < 0 || i >= HMAX) ? 0 : hd[i];
    endfunction

    function automatic int hvx(int i);
        return (i < 0 || i >= HMAX) ? 0 : hv[i];
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic int gen(int pat, int j);
        int col, line, h;
        col  = j % LL;
        line = j / LL;
        h    = ((j * 97) ^ (j * j * 13) ^ 91) & 255;
        case (pat)
            0:       return (col * 23 + line * 2 + (h & 1)) & 255;
            1:       return h;
            2:       return (col * 23) & 255;
            default: return (h * 7 + 3) & 255;
        endcase
    endfunction

    function automatic int thr_of(int pat);
        case (pat)
            0:       return 10;
            1:       return 10;
            2:       return 0;
            default: return 255;
        endcase
    endfunction

    task automatic check(string tag, int act, int expv, string what);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (std=%0d mode=%0d pat=%0d edge=%0d)",
                     tag, what, act, expv, cur_std, cur_mode, cur_pat, e);
        end
    endtask

    task automatic drive(int idx, int j);
        int v, d;
        d = gen(cur_pat, j);
        v = ((j % 13) != 5) ? 1 : 0;
        cvbs_in  = d[7:0];
        in_valid = v[0];
        if (idx < HMAX) begin
            hd[idx] = d;
            hv[idx] = v;
        end
    endtask

    task automatic verify(int m);
        int k, c0, up, dn, lf, rt, yc, yb, ye, ce, th, cact;
        string ytag;
        bit comb;
        k  = m - span - 19;
        c0 = hx(k);
        up = hx(k + span);
        dn = hx(k - span);
        lf = hx(k - 2);
        rt = hx(k + 2);
        th = thr_of(cur_pat);
        yc = (up + 2 * c0 + dn) / 4;
        yb = (lf + 2 * c0 + rt) / 4;
        comb = (absd(up, c0) < th) && (absd(dn, c0) < th);
        if (cur_mode == 3) begin
            ye = c0;  ytag = "R3";
        end else if (cur_mode == 2) begin
            ye = yb;  ytag = "R4";
        end else begin
            ye = comb ? yc : yb;
            if (th == 0)          ytag = "R7";
            else if (cur_std != 0) ytag = "R8";
            else                   ytag = "R5";
        end
        ce   = c0 - ye;
        cact = int'($signed(c_out));
        check("R2", int'(out_valid), hvx(k), "out_valid");
        check(ytag, int'(y_out), ye, "y_out");
        check("R6", cact, ce, "c_out");
    endtask

    task automatic run(int std, int mode, int pat);
        int j;
        cur_std  = std;
        cur_mode = mode;
        cur_pat  = pat;
        tv_std      = std[1:0];
        sep_mode    = mode[1:0];
        corr_thresh = 8'(thr_of(pat));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        cvbs_in  = 8'd0;
        for (int i = 0; i < HMAX; i++) begin
            hd[i] = 0;
            hv[i] = 0;
        end
        span = (std == 0) ? LL : 2 * LL;
        e = 0;
        repeat (3) begin
            @(posedge clk);
            e++;
        end
        @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid after reset");
        check("R1", int'(y_out), 0, "y_out after reset");
        check("R1", int'(c_out), 0, "c_out after reset");
        rst_n = 1'b1;
        j = 0;
        drive(e + 1, j);
        repeat (2 * span + LAT + NSAMP) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            verify(e);
            j++;
            drive(e + 1, j);
        end
    endtask

    initial begin
        for (int s = 0; s < 4; s++)
            for (int md = 0; md < 4; md++)
                for (int p = 0; p < 4; p++)
                    run(s, md, p);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule